// File: doc/BRIEF.md
# Pipelined Fixed-Point Twiddle Multiplier

This block multiplies a complex data sample by a complex twiddle factor in a streaming FFT datapath. It sits after a pair of decimation-in-frequency butterflies, so the data operand has already gained one bit per butterfly. The default is 18-bit FFT input plus two growth bits, which gives 20 bits. The twiddle operand is the stored twiddle widened by one bit, so the value +1 is exactly representable. At the defaults this is a 19-bit operand, and +1 is 2^17.

A build-time option picks one of two arithmetic forms. The four-product form computes the real and imaginary parts on separate paths. The three-product form uses widened pre-adders, needs three quarters of the real multipliers, and gives the same bits. Any real product whose operand is wider than the multiplier primitive is assembled from four narrower partial products, which are then summed. The full-precision result is scaled down by the twiddle's fraction length. It is rounded half-to-even and then clamped to the output width. Both forms have the same fixed latency, and a valid flag travels with the data.

Top module: `cmult_top`

## Requirements
- R1: In the four-product form, once a valid sample has passed through, y_re equals Q(ar*br − ai*bi) and y_im equals Q(ar*bi + ai*br). Here ar/ai are d_re/d_im, br/bi are w_re/w_im (all two's complement), and Q() is the rounding and clamping of R4 and R5.
- R2: The three-product form produces, every cycle, exactly the same out_valid, y_re and y_im as the four-product form for the same inputs.
- R3: A twiddle of (2^(TW_W−2), 0) returns the data unchanged. A twiddle of (0, 2^(TW_W−2)) returns (−d_im, d_re).
- R4: Q() divides by 2^(TW_W−2) and rounds to nearest. An exact half goes to the even neighbour, so +0.5→0, +1.5→2, −0.5→0 and −1.5→−2.
- R5: A rounded result above 2^(OUT_W−1)−1 is output as 2^(OUT_W−1)−1. A result below −2^(OUT_W−1) is output as −2^(OUT_W−1).
- R6: out_valid is in_valid delayed by exactly 6 clock cycles, in both forms.
- R7: Data parts at −2^(DATA_W−1) and twiddle parts at −2^(TW_W−1) or 2^(TW_W−1)−1 are processed without internal wrap-around. The results follow R1, R4 and R5.
- R8: While out_valid is low, y_re and y_im are zero, whatever data arrives with in_valid low.
- R9: While rst_n is low, out_valid, y_re and y_im are zero.
- R10: A new sample may be accepted on every cycle, and back-to-back samples each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is valid this cycle |
| d_re | input | DATA_W | Data real part, signed |
| d_im | input | DATA_W | Data imaginary part, signed |
| w_re | input | TW_W | Twiddle real part, signed, +1 = 2^(TW_W−2) |
| w_im | input | TW_W | Twiddle imaginary part, signed |
| out_valid | output | 1 | Result is valid this cycle |
| y_re | output | OUT_W | Rounded, clamped real result |
| y_im | output | OUT_W | Rounded, clamped imaginary result |

## Verification
The hardest situations to reach from the ports are an exact rounding tie and the extreme operand corners where the widened pre-adders and the partial-product sum are at full range. Random data almost never lands on them. The stimulus therefore drives a half-scale twiddle with small odd data, which places each result exactly on a half. It also drives directed samples with every part at the most negative value, paired with twiddles of both extreme signs. Two instances, one of each form, take the same back-to-back and gapped streams, and each result is compared with a wide-integer reference in the cycle it is due.

// File: rtl/cmult_pkg.sv
package cmult_pkg;
   // Registers from input to output, identical for both arithmetic forms.
   localparam int unsigned CMULT_LATENCY = 6;

   typedef enum logic {
      ARCH_FOUR  = 1'b0,
      ARCH_THREE = 1'b1
   } cmult_arch_e;
endpackage

// File: rtl/cmult_wide_mul.sv
// Signed multiply with two register stages. Operands wider than the
// primitive are split into an unsigned low chunk of PRIM_W-1 bits and a
// signed high chunk; the four partial products are then summed.
module cmult_wide_mul #(
   parameter int A_W    = 20,
   parameter int B_W    = 19,
   parameter int PRIM_W = 18
) (
   input  logic                     clk,
   input  logic signed [A_W-1:0]    a,
   input  logic signed [B_W-1:0]    b,
   output logic signed [A_W+B_W-1:0] p
);
   localparam int L   = PRIM_W - 1;
   localparam int P_W = A_W + B_W;

   generate
      if (A_W <= PRIM_W && B_W <= PRIM_W) begin : g_single
         logic signed [P_W-1:0] prod_q;
         logic signed [P_W-1:0] prod_qq;
         always_ff @(posedge clk) begin
            prod_q  <= a * b;
            prod_qq <= prod_q;
         end
         assign p = prod_qq;
      end else begin : g_split
         localparam int AX = (A_W > L) ? A_W : L + 1;
         localparam int BX = (B_W > L) ? B_W : L + 1;
         localparam int AH = AX - L;
         localparam int BH = BX - L;

         logic signed [AX-1:0] a_ext;
         logic signed [BX-1:0] b_ext;
         logic signed [L:0]    a_lo, b_lo;
         logic signed [AH-1:0] a_hi;
         logic signed [BH-1:0] b_hi;

         assign a_ext = AX'(a);
         assign b_ext = BX'(b);
         assign a_lo  = {1'b0, a_ext[L-1:0]};
         assign b_lo  = {1'b0, b_ext[L-1:0]};
         assign a_hi  = a_ext[AX-1:L];
         assign b_hi  = b_ext[BX-1:L];

         logic signed [2*L+1:0]  pp_ll;
         logic signed [BH+L:0]   pp_lh;
         logic signed [AH+L:0]   pp_hl;
         logic signed [AH+BH-1:0] pp_hh;
         logic signed [P_W-1:0]  sum_q;

         always_ff @(posedge clk) begin
            pp_ll <= a_lo * b_lo;
            pp_lh <= a_lo * b_hi;
            pp_hl <= a_hi * b_lo;
            pp_hh <= a_hi * b_hi;
            sum_q <= (P_W'(pp_hh) <<< (2 * L))
                   + ((P_W'(pp_lh) + P_W'(pp_hl)) <<< L)
                   + P_W'(pp_ll);
         end
         assign p = sum_q;
      end
   endgenerate
endmodule

// File: rtl/cmult_round_sat.sv
// Drops SHIFT fraction bits with round-half-to-even, clamps to OUT_W and
// registers the result; the register is zero when the sample is not valid.
module cmult_round_sat #(
   parameter int IN_W  = 41,
   parameter int SHIFT = 17,
   parameter int OUT_W = 20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_v,
   input  logic signed [IN_W-1:0]  x,
   output logic signed [OUT_W-1:0] y
);
   localparam int QW = IN_W - SHIFT + 1;

   logic signed [QW-2:0]  whole;
   logic [SHIFT-1:0]      frac;
   logic                  bump;
   logic signed [QW-1:0]  rounded;
   logic signed [OUT_W-1:0] clamped;

   assign whole   = x[IN_W-1:SHIFT];
   assign frac    = x[SHIFT-1:0];
   assign bump    = frac[SHIFT-1] & ((|frac[SHIFT-2:0]) | whole[0]);
   assign rounded = {whole[QW-2], whole} + {{(QW-1){1'b0}}, bump};

   generate
      if (QW > OUT_W) begin : g_clamp
         localparam logic signed [QW-1:0] MAXV = {{(QW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
         localparam logic signed [QW-1:0] MINV = {{(QW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
         always_comb begin
            if (rounded > MAXV)      clamped = MAXV[OUT_W-1:0];
            else if (rounded < MINV) clamped = MINV[OUT_W-1:0];
            else                     clamped = rounded[OUT_W-1:0];
         end
      end else begin : g_extend
         assign clamped = OUT_W'(rounded);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    y <= '0;
      else if (in_v) y <= clamped;
      else           y <= '0;
   end
endmodule

// File: rtl/cmult_top.sv
module cmult_top
   import cmult_pkg::*;
#(
   parameter int          DATA_W = 20,
   parameter int          TW_W   = 19,
   parameter int          OUT_W  = 20,
   parameter int          PRIM_W = 18,
   parameter cmult_arch_e ARCH   = ARCH_FOUR
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] d_re,
   input  logic signed [DATA_W-1:0] d_im,
   input  logic signed [TW_W-1:0]   w_re,
   input  logic signed [TW_W-1:0]   w_im,
   output logic                     out_valid,
   output logic signed [OUT_W-1:0]  y_re,
   output logic signed [OUT_W-1:0]  y_im
);
   localparam int LAT    = CMULT_LATENCY;
   localparam int PW     = DATA_W + TW_W;
   localparam int FULL_W = PW + 2;
   localparam int SHIFT  = TW_W - 2;

   initial begin
      if (DATA_W < 2 || TW_W < 4 || PRIM_W < 2 || OUT_W < 2)
         $fatal(1, "cmult_top: widths too small");
      if (DATA_W + 1 > 2 * PRIM_W - 1 || TW_W + 1 > 2 * PRIM_W - 1)
         $fatal(1, "cmult_top: operand exceeds one split level");
      if (OUT_W > FULL_W - SHIFT)
         $fatal(1, "cmult_top: output wider than full result");
   end

   // Valid travels beside the datapath.
   logic [LAT-1:0] vld;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld <= '0;
      else        vld <= {vld[LAT-2:0], in_valid};
   end
   assign out_valid = vld[LAT-1];

   // Stage 1: capture operands.
   logic signed [DATA_W-1:0] ar, ai;
   logic signed [TW_W-1:0]   br, bi;
   always_ff @(posedge clk) begin
      ar <= d_re;
      ai <= d_im;
      br <= w_re;
      bi <= w_im;
   end

   logic signed [FULL_W-1:0] re_full, im_full;

   generate
      if (ARCH == ARCH_FOUR) begin : g_four
         // Stage 2 only holds operands so both forms share one latency.
         logic signed [DATA_W-1:0] ar2, ai2;
         logic signed [TW_W-1:0]   br2, bi2;
         logic signed [PW-1:0]     p_rr, p_ii, p_ri, p_ir;
         always_ff @(posedge clk) begin
            ar2 <= ar;
            ai2 <= ai;
            br2 <= br;
            bi2 <= bi;
         end
         cmult_wide_mul #(.A_W(DATA_W), .B_W(TW_W), .PRIM_W(PRIM_W))
            u_rr (.clk(clk), .a(ar2), .b(br2), .p(p_rr));
         cmult_wide_mul #(.A_W(DATA_W), .B_W(TW_W), .PRIM_W(PRIM_W))
            u_ii (.clk(clk), .a(ai2), .b(bi2), .p(p_ii));
         cmult_wide_mul #(.A_W(DATA_W), .B_W(TW_W), .PRIM_W(PRIM_W))
            u_ri (.clk(clk), .a(ar2), .b(bi2), .p(p_ri));
         cmult_wide_mul #(.A_W(DATA_W), .B_W(TW_W), .PRIM_W(PRIM_W))
            u_ir (.clk(clk), .a(ai2), .b(br2), .p(p_ir));
         always_ff @(posedge clk) begin
            re_full <= FULL_W'(p_rr) - FULL_W'(p_ii);
            im_full <= FULL_W'(p_ri) + FULL_W'(p_ir);
         end
      end else begin : g_three
         // Stage 2: pre-adders, one bit wider than their inputs.
         logic signed [DATA_W:0]   s_data;
         logic signed [TW_W:0]     s_dif, s_sum;
         logic signed [DATA_W-1:0] ar2, ai2;
         logic signed [TW_W-1:0]   br2;
         logic signed [PW:0]       k1, k2, k3;
         always_ff @(posedge clk) begin
            s_data <= (DATA_W+1)'(ar) + (DATA_W+1)'(ai);
            s_dif  <= (TW_W+1)'(bi) - (TW_W+1)'(br);
            s_sum  <= (TW_W+1)'(br) + (TW_W+1)'(bi);
            ar2    <= ar;
            ai2    <= ai;
            br2    <= br;
         end
         cmult_wide_mul #(.A_W(DATA_W+1), .B_W(TW_W), .PRIM_W(PRIM_W))
            u_k1 (.clk(clk), .a(s_data), .b(br2), .p(k1));
         cmult_wide_mul #(.A_W(DATA_W), .B_W(TW_W+1), .PRIM_W(PRIM_W))
            u_k2 (.clk(clk), .a(ar2), .b(s_dif), .p(k2));
         cmult_wide_mul #(.A_W(DATA_W), .B_W(TW_W+1), .PRIM_W(PRIM_W))
            u_k3 (.clk(clk), .a(ai2), .b(s_sum), .p(k3));
         always_ff @(posedge clk) begin
            re_full <= FULL_W'(k1) - FULL_W'(k3);
            im_full <= FULL_W'(k1) + FULL_W'(k2);
         end
      end
   endgenerate

   // Stage 6: round and clamp.
   cmult_round_sat #(.IN_W(FULL_W), .SHIFT(SHIFT), .OUT_W(OUT_W))
      u_rs_re (.clk(clk), .rst_n(rst_n), .in_v(vld[LAT-2]), .x(re_full), .y(y_re));
   cmult_round_sat #(.IN_W(FULL_W), .SHIFT(SHIFT), .OUT_W(OUT_W))
      u_rs_im (.clk(clk), .rst_n(rst_n), .in_v(vld[LAT-2]), .x(im_full), .y(y_im));
endmodule

// File: rtl/cmult_checker.sv
module cmult_checker
   import cmult_pkg::*;
#(
   parameter int DATA_W = 20,
   parameter int TW_W   = 19,
   parameter int OUT_W  = 20
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic signed [DATA_W-1:0] d_re,
   input logic signed [DATA_W-1:0] d_im,
   input logic signed [TW_W-1:0]   w_re,
   input logic signed [TW_W-1:0]   w_im,
   input logic                     out_valid,
   input logic signed [OUT_W-1:0]  y_re,
   input logic signed [OUT_W-1:0]  y_im
);
   localparam int LAT = CMULT_LATENCY;
   localparam logic [2:0] LAT3 = 3'(LAT);
   localparam logic signed [TW_W-1:0] ONE = {2'b01, {(TW_W-2){1'b0}}};

   // Cycles since reset release, saturating; guards every look into the past.
   logic [2:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cyc <= '0;
      else if (cyc != 3'd7)  cyc <= cyc + 3'd1;
   end
   logic hist_ok;
   assign hist_ok = (cyc >= LAT3);

   assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hist_ok |-> (out_valid == $past(in_valid, LAT)));

   assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (y_re == '0 && y_im == '0));

   assert_zero_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok && out_valid && $past(d_re, LAT) == '0 && $past(d_im, LAT) == '0)
      |-> (y_re == '0 && y_im == '0));

   generate
      if (OUT_W >= DATA_W) begin : g_unit
         assert_unit_twiddle_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (hist_ok && out_valid && $past(w_re, LAT) == ONE && $past(w_im, LAT) == '0)
            |-> (y_re == OUT_W'($past(d_re, LAT)) && y_im == OUT_W'($past(d_im, LAT))));
      end
   endgenerate
endmodule

bind cmult_top cmult_checker #(.DATA_W(DATA_W), .TW_W(TW_W), .OUT_W(OUT_W)) u_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .d_re(d_re), .d_im(d_im), .w_re(w_re), .w_im(w_im),
   .out_valid(out_valid), .y_re(y_re), .y_im(y_im));

// File: tb/cmult_top_test.sv
`timescale 1ns/1ps
module cmult_top_test;
   localparam int DW = 20;
   localparam int TW = 19;
   localparam int OW = 20;
   localparam int SH = TW - 2;
   localparam int LAT = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [DW-1:0] d_re = '0, d_im = '0;
   logic signed [TW-1:0] w_re = '0, w_im = '0;
   logic                 v4, v3;
   logic signed [OW-1:0] yr4, yi4, yr3, yi3;

   always #2.5 clk = ~clk;

   cmult_top #(.DATA_W(DW), .TW_W(TW), .OUT_W(OW), .PRIM_W(18), .ARCH(cmult_pkg::ARCH_FOUR)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .d_re(d_re), .d_im(d_im),
      .w_re(w_re), .w_im(w_im), .out_valid(v4), .y_re(yr4), .y_im(yi4));

   cmult_top #(.DATA_W(DW), .TW_W(TW), .OUT_W(OW), .PRIM_W(18), .ARCH(cmult_pkg::ARCH_THREE)) uut_m3 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .d_re(d_re), .d_im(d_im),
      .w_re(w_re), .w_im(w_im), .out_valid(v3), .y_re(yr3), .y_im(yi3));

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;
   bit running = 1'b0;
   string cur_tag = "R8";

   // Reference: round half to even by 2^SH, then clamp to OW bits.
   function automatic longint shape(input longint x);
      longint q, r, half, maxv, minv;
      q    = x >>> SH;
      r    = x - (q <<< SH);
      half = 64'sd1 <<< (SH - 1);
      if (r > half || (r == half && q[0])) q = q + 1;
      maxv = (64'sd1 <<< (OW - 1)) - 1;
      minv = -(64'sd1 <<< (OW - 1));
      if (q > maxv) q = maxv;
      if (q < minv) q = minv;
      return q;
   endfunction

   function automatic longint rnd(input int w);
      longint u;
      u = longint'({$urandom(), $urandom()});
      u = u & ((64'sd1 <<< w) - 1);
      if (u >= (64'sd1 <<< (w - 1))) u = u - (64'sd1 <<< w);
      return u;
   endfunction

   // Expected-value delay line, one entry per register stage.
   bit     e_v[LAT];
   longint e_re[LAT], e_im[LAT];
   string  e_tag[LAT];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LAT; i++) begin
            e_v[i] = 1'b0; e_re[i] = 0; e_im[i] = 0; e_tag[i] = "R9";
         end
      end else begin
         for (int i = LAT - 1; i > 0; i--) begin
            e_v[i] = e_v[i-1]; e_re[i] = e_re[i-1]; e_im[i] = e_im[i-1]; e_tag[i] = e_tag[i-1];
         end
         e_v[0] = in_valid;
         if (in_valid) begin
            e_re[0] = shape(longint'(d_re) * longint'(w_re) - longint'(d_im) * longint'(w_im));
            e_im[0] = shape(longint'(d_re) * longint'(w_im) + longint'(d_im) * longint'(w_re));
            e_tag[0] = cur_tag;
         end else begin
            e_re[0] = 0; e_im[0] = 0; e_tag[0] = "R8";
         end
      end
   end

   task automatic check_one(input string who, input string extra, input logic v,
                            input logic signed [OW-1:0] yr, input logic signed [OW-1:0] yi);
      compared++;
      if (v !== e_v[LAT-1] || longint'(yr) != e_re[LAT-1] || longint'(yi) != e_im[LAT-1]) begin
         mismatched++;
         $display("FAIL %s%s %s: got v=%0b re=%0d im=%0d, expected v=%0b re=%0d im=%0d",
                  extra, e_tag[LAT-1], who, v, yr, yi, e_v[LAT-1], e_re[LAT-1], e_im[LAT-1]);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && running) begin
         check_one("four-form", "", v4, yr4, yi4);
         check_one("three-form", "R2/", v3, yr3, yi3);
      end
   end

   task automatic send(input longint dr, input longint di, input longint wr, input longint wi,
                       input string tag);
      @(negedge clk);
      d_re = DW'(dr); d_im = DW'(di); w_re = TW'(wr); w_im = TW'(wi);
      in_valid = 1'b1;
      cur_tag = tag;
   endtask

   // Gap cycles carry junk data that must leave no trace (R8).
   task automatic gap(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         d_re = DW'(rnd(DW)); d_im = DW'(rnd(DW));
         w_re = TW'(rnd(TW)); w_im = TW'(rnd(TW));
      end
   endtask

   localparam longint ONE  = 64'sd1 <<< SH;
   localparam longint DMIN = -(64'sd1 <<< (DW - 1));
   localparam longint TMIN = -(64'sd1 <<< (TW - 1));
   localparam longint TMAX = (64'sd1 <<< (TW - 1)) - 1;

   initial begin
      // R9: outputs held at zero during reset even with valid input present.
      in_valid = 1'b1; d_re = 20'sd1000; d_im = -20'sd77; w_re = 19'sd5000; w_im = 19'sd9;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         compared++;
         if (v4 !== 1'b0 || yr4 !== '0 || yi4 !== '0 || v3 !== 1'b0 || yr3 !== '0 || yi3 !== '0) begin
            mismatched++;
            $display("FAIL R9 reset: got v=%0b/%0b re=%0d/%0d im=%0d/%0d, expected all 0",
                     v4, v3, yr4, yr3, yi4, yi3);
         end
      end
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      running = 1'b1;
      gap(4);

      // R3: unit twiddle and unit imaginary twiddle.
      for (int i = 0; i < 16; i++) send(rnd(DW), rnd(DW), ONE, 0, "R3");
      for (int i = 0; i < 8; i++)  send(rnd(DW), rnd(DW), 0, ONE, "R3");
      send(DMIN, DMIN, ONE, 0, "R3");
      gap(3);

      // R4: exact ties with a half-scale twiddle.
      send(1, 3, ONE / 2, 0, "R4");
      send(-1, -3, ONE / 2, 0, "R4");
      send(5, -5, ONE / 2, 0, "R4");
      send(7, 9, 0, ONE / 2, "R4");
      send(3, 1, ONE / 2, ONE / 2, "R4");
      gap(2);

      // R7: extreme operand corners.
      send(DMIN, DMIN, TMIN, TMIN, "R7");
      send(DMIN, DMIN, TMIN, TMAX, "R7");
      send(DMIN, DMIN, TMAX, TMIN, "R7");
      send(DMIN, -DMIN - 1, TMAX, TMAX, "R7");
      send(-DMIN - 1, DMIN, TMIN, TMAX, "R7");
      gap(2);

      // R5: large operands that drive the result past the output range.
      for (int i = 0; i < 20; i++)
         send(DMIN + longint'($urandom_range(0, 4000)), -DMIN - 1 - longint'($urandom_range(0, 4000)),
              TMAX - longint'($urandom_range(0, 4000)), TMAX - longint'($urandom_range(0, 4000)), "R5");
      gap(2);

      // R1 and R10: back-to-back random samples.
      for (int i = 0; i < 300; i++) send(rnd(DW), rnd(DW), rnd(TW), rnd(TW), "R1/R10");

      // R6: isolated samples with random gaps.
      for (int i = 0; i < 60; i++) begin
         send(rnd(DW), rnd(DW), rnd(TW - 1), rnd(TW - 1), "R6");
         gap(int'($urandom_range(0, 7)));
      end

      gap(LAT + 4);
      running = 1'b0;
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule